// File: doc/BRIEF.md
# Floating-point register stack exchange unit

This block keeps an eight-slot floating-point register stack: eight 80-bit value slots, one valid/empty tag for each slot and a 3-bit top pointer. It executes one instruction, the stack exchange. The exchange trades the value at the stack top, ST(0), with the value in ST(i), where i is a 3-bit operand taken from the instruction's second byte. Stack-relative index i maps to physical slot (top + i) mod 8. The exchange does not move the top pointer. This lets software bring any stacked value to the top, work on it there, and put it back.

Before anything changes, the unit checks for faults in a fixed order. A locked instruction gives an invalid-opcode fault. If either control bit EM or TS is set, it gives a device-not-available fault. A pending floating-point exception gives a math fault. Last comes the check for a stack underflow, which happens when a slot taking part in the swap is empty. Each fault is reported as a one-cycle strobe. When invalid-operation exceptions are masked, an underflow does not block the swap: each empty operand is replaced by the default indefinite value and then exchanged. A debug port reads and writes slots by stack-relative index. It can also free a slot, load the top pointer and load the condition flag C1.

Top module: `fpstk_xchg`

## Requirements
- R1: An instruction is an exchange only when op_b0 = 8'hD9 and op_b1[7:3] = 5'b11001 (bytes C8 to CF). The operand is i = op_b1[2:0], so C9 selects i = 1. An issue with any other byte pair produces no strobe and changes no state.
- R2: ST(k) is physical slot (top_ptr + k) mod 8, both for the exchange and for the debug port. An exchange leaves top_ptr unchanged.
- R3: In the cycle after an exchange with no fault is issued, done is high for one cycle and ST(0) and ST(i) hold each other's former values. All other slots are unchanged. With i = 0 the stack is unchanged.
- R4: After a completed exchange, or after any underflow, c1 reads 0.
- R5: If lock_pfx is set during an exchange, flt_ud pulses. This fault has the highest priority.
- R6: If lock_pfx is clear and cr_em or cr_ts is set, flt_nm pulses.
- R7: If lock_pfx, cr_em and cr_ts are all clear and fp_pend is set, flt_mf pulses.
- R8: With no higher-priority fault, an empty ST(0) or ST(i) pulses flt_is. If inv_mask = 0, the stack is left unchanged. If inv_mask = 1, each empty operand takes the value 80'hFFFF_C000_0000_0000_0000 and is marked valid, the swap then takes place, and done pulses.
- R9: After flt_ud, flt_nm or flt_mf, the values, the tags, top_ptr and c1 are all unchanged. At most one fault strobe is high in any cycle.
- R10: Reset empties every slot and clears top_ptr and c1. dbg_we writes dbg_wdata into ST(dbg_idx) and marks it valid. dbg_free marks ST(dbg_idx) empty. dbg_top_we loads top_ptr. dbg_c1_we loads c1. All debug writes are ignored in any cycle where issue is high. dbg_rdata and dbg_rtag show ST(dbg_idx) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| op_b0 | input | 8 | First instruction byte |
| op_b1 | input | 8 | Second instruction byte |
| lock_pfx | input | 1 | Lock prefix present |
| cr_em | input | 1 | Control bit EM (emulate) |
| cr_ts | input | 1 | Control bit TS (task switched) |
| fp_pend | input | 1 | An unmasked floating-point exception is pending |
| inv_mask | input | 1 | Invalid-operation exception is masked |
| dbg_idx | input | 3 | Stack-relative slot for debug read and write |
| dbg_we | input | 1 | Write the value and mark the slot valid |
| dbg_free | input | 1 | Mark the slot empty |
| dbg_wdata | input | 80 | Debug write value |
| dbg_top_we | input | 1 | Load the top pointer |
| dbg_top | input | 3 | New top pointer |
| dbg_c1_we | input | 1 | Load C1 |
| dbg_c1 | input | 1 | New C1 value |
| dbg_rdata | output | 80 | Value of ST(dbg_idx) |
| dbg_rtag | output | 1 | 1 when ST(dbg_idx) is valid |
| top_ptr | output | 3 | Current top pointer |
| c1 | output | 1 | Condition flag C1 |
| done | output | 1 | One-cycle pulse: a swap was performed |
| flt_ud | output | 1 | One-cycle pulse: invalid-opcode fault |
| flt_nm | output | 1 | One-cycle pulse: device-not-available fault |
| flt_mf | output | 1 | One-cycle pulse: math fault |
| flt_is | output | 1 | One-cycle pulse: stack underflow |

## Verification
The assertions check on every cycle that the fault strobes stay mutually exclusive. They also check that the lock and control-bit faults follow a matching exchange one cycle later, that top_ptr never moves on an exchange, that c1 is low after a swap, and that tags, c1 and top_ptr do not change after a blocking fault or an unmasked underflow. Only the bench's scenarios can show that the values themselves move correctly: the swap at every top and index, the substitution of the indefinite value, the wrap of the stack-relative index, and whether debug writes are ignored during an issue. The bench sweeps every top and index pair and every combination of the four fault inputs against a model of the stack.

// File: rtl/fpstk_xchg.sv
module fpstk_xchg #(
  parameter int W = 80,
  parameter logic [W-1:0] INDEF = 80'hFFFF_C000_0000_0000_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [7:0]   op_b0,
  input  logic [7:0]   op_b1,
  input  logic         lock_pfx,
  input  logic         cr_em,
  input  logic         cr_ts,
  input  logic         fp_pend,
  input  logic         inv_mask,
  input  logic [2:0]   dbg_idx,
  input  logic         dbg_we,
  input  logic         dbg_free,
  input  logic [W-1:0] dbg_wdata,
  input  logic         dbg_top_we,
  input  logic [2:0]   dbg_top,
  input  logic         dbg_c1_we,
  input  logic         dbg_c1,
  output logic [W-1:0] dbg_rdata,
  output logic         dbg_rtag,
  output logic [2:0]   top_ptr,
  output logic         c1,
  output logic         done,
  output logic         flt_ud,
  output logic         flt_nm,
  output logic         flt_mf,
  output logic         flt_is
);
  localparam int N = 8;

  logic [W-1:0] slot [N];
  logic [N-1:0] tag;
  logic [2:0]   top;

  logic       hit, blk_ud, blk_nm, blk_mf, uflow, go, is_f;
  logic [2:0] pa, pb, dptr;
  logic [W-1:0] va, vb;

  assign hit    = issue && op_b0 == 8'hD9 && op_b1[7:3] == 5'b11001;
  assign pa     = top;
  assign pb     = top + op_b1[2:0];
  assign uflow  = !tag[pa] || !tag[pb];
  assign blk_ud = hit && lock_pfx;
  assign blk_nm = hit && !lock_pfx && (cr_em || cr_ts);
  assign blk_mf = hit && !lock_pfx && !cr_em && !cr_ts && fp_pend;
  assign is_f   = hit && !lock_pfx && !cr_em && !cr_ts && !fp_pend && uflow;
  assign go     = hit && !lock_pfx && !cr_em && !cr_ts && !fp_pend && (!uflow || inv_mask);
  assign va     = tag[pa] ? slot[pa] : INDEF;
  assign vb     = tag[pb] ? slot[pb] : INDEF;

  assign dptr      = top + dbg_idx;
  assign dbg_rdata = slot[dptr];
  assign dbg_rtag  = tag[dptr];
  assign top_ptr   = top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) slot[k] <= '0;
      tag    <= '0;
      top    <= '0;
      c1     <= 1'b0;
      done   <= 1'b0;
      flt_ud <= 1'b0;
      flt_nm <= 1'b0;
      flt_mf <= 1'b0;
      flt_is <= 1'b0;
    end else begin
      done   <= go;
      flt_ud <= blk_ud;
      flt_nm <= blk_nm;
      flt_mf <= blk_mf;
      flt_is <= is_f;
      if (go) begin
        slot[pa] <= vb;
        slot[pb] <= va;
        tag[pa]  <= 1'b1;
        tag[pb]  <= 1'b1;
        c1       <= 1'b0;
      end else if (is_f) begin
        c1 <= 1'b0;
      end else if (!issue) begin
        if (dbg_we) begin
          slot[dptr] <= dbg_wdata;
          tag[dptr]  <= 1'b1;
        end else if (dbg_free) begin
          tag[dptr] <= 1'b0;
        end
        if (dbg_top_we) top <= dbg_top;
        if (dbg_c1_we)  c1  <= dbg_c1;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_ud, flt_nm, flt_mf, flt_is})); // R9
  AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hit && lock_pfx |=> flt_ud && !done); // R5
  AST_DEV_NA: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !lock_pfx && (cr_em || cr_ts) |=> flt_nm && !done); // R6
  AST_MATH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !lock_pfx && !cr_em && !cr_ts && fp_pend |=> flt_mf && !done); // R7
  AST_TOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> top == $past(top)); // R2
  AST_C1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !c1); // R4
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_ud || flt_nm || flt_mf) |-> $stable(tag) && $stable(c1) && $stable(top)); // R9
  AST_UFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flt_is && !done |-> $stable(tag) && !c1); // R8
endmodule

// File: tb/sim_fpstk_xchg.sv
module sim_fpstk_xchg;
  localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 0, lock_pfx = 0, cr_em = 0, cr_ts = 0, fp_pend = 0, inv_mask = 0;
  logic [7:0] op_b0 = 0, op_b1 = 0;
  logic [2:0] dbg_idx = 0, dbg_top = 0;
  logic dbg_we = 0, dbg_free = 0, dbg_top_we = 0, dbg_c1_we = 0, dbg_c1 = 0;
  logic [79:0] dbg_wdata = 0, dbg_rdata;
  logic dbg_rtag, c1, done, flt_ud, flt_nm, flt_mf, flt_is;
  logic [2:0] top_ptr;

  int nvec = 0, nfail = 0;
  logic [79:0] mv [8];
  logic [7:0]  mt;
  logic [2:0]  mtop;
  logic        mc1;

  always #5 clk = ~clk;

  fpstk_xchg u0 (.*);

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] k, input logic [79:0] v);
    dbg_idx = k; dbg_wdata = v; dbg_we = 1; tick(); dbg_we = 0;
    mv[mtop + k] = v; mt[mtop + k] = 1'b1;
  endtask

  task automatic free(input logic [2:0] k);
    dbg_idx = k; dbg_free = 1; tick(); dbg_free = 0;
    mt[mtop + k] = 1'b0;
  endtask

  task automatic set_top(input logic [2:0] t);
    dbg_top = t; dbg_top_we = 1; tick(); dbg_top_we = 0; mtop = t;
  endtask

  task automatic set_c1(input logic b);
    dbg_c1 = b; dbg_c1_we = 1; tick(); dbg_c1_we = 0; mc1 = b;
  endtask

  task automatic fill(input int seed);
    for (int k = 0; k < 8; k++)
      wr(3'(k), {8'(seed), 8'(k), 64'hDEAD_0000_0000_0000 + 64'(seed * 64 + k)});
  endtask

  task automatic check_state(input string req);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] p;
      p = mtop + 3'(k);
      dbg_idx = 3'(k);
      #1;
      chk(req, 80'(dbg_rtag), 80'(mt[p]));
      if (mt[p]) chk(req, dbg_rdata, mv[p]);
    end
    chk(req, 80'(top_ptr), 80'(mtop));
    chk(req, 80'(c1), 80'(mc1));
  endtask

  task automatic xchg(input string req, input logic [7:0] b0, input logic [7:0] b1,
                      input logic lk, input logic em, input logic ts, input logic pd, input logic msk);
    logic h, eu, en, ef, ei, ed, uf;
    logic [2:0] pa, pb;
    logic [79:0] a, b;
    h  = b0 == 8'hD9 && b1 >= 8'hC8 && b1 <= 8'hCF;
    pa = mtop; pb = mtop + b1[2:0];
    uf = !mt[pa] || !mt[pb];
    eu = h && lk;
    en = h && !lk && (em || ts);
    ef = h && !lk && !em && !ts && pd;
    ei = h && !lk && !em && !ts && !pd && uf;
    ed = h && !lk && !em && !ts && !pd && (!uf || msk);
    op_b0 = b0; op_b1 = b1; lock_pfx = lk; cr_em = em; cr_ts = ts; fp_pend = pd; inv_mask = msk;
    issue = 1;
    tick();
    issue = 0; lock_pfx = 0; cr_em = 0; cr_ts = 0; fp_pend = 0;
    chk({req, " strobes"}, {75'd0, done, flt_ud, flt_nm, flt_mf, flt_is}, {75'd0, ed, eu, en, ef, ei});
    if (ed) begin
      a = mt[pa] ? mv[pa] : INDEF;
      b = mt[pb] ? mv[pb] : INDEF;
      mv[pa] = b; mv[pb] = a; mt[pa] = 1; mt[pb] = 1; mc1 = 0;
    end else if (ei) mc1 = 0;
    tick();
    chk({req, " pulse"}, {77'd0, done, flt_ud, flt_is}, 80'd0);
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    mt = 0; mtop = 0; mc1 = 0;
    for (int k = 0; k < 8; k++) mv[k] = 0;
    repeat (3) tick();
    rst_n = 1;
    #1;
    chk("R10 reset strobes", {75'd0, done, flt_ud, flt_nm, flt_mf, flt_is}, 80'd0);
    check_state("R10 reset");

    // R3 R2 R4: every top and every index, long form
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 8; i++) begin
        set_top(3'(t));
        fill(t * 8 + i);
        set_c1(1'b1);
        xchg("R3 swap", 8'hD9, 8'hC8 + 8'(i), 0, 0, 0, 0, 0);
      end

    // R1: short form equals i = 1
    for (int t = 0; t < 8; t += 3) begin
      set_top(3'(t)); fill(100 + t); set_c1(1'b1);
      xchg("R1 short form", 8'hD9, 8'hC9, 0, 0, 0, 0, 0);
    end

    // R1: non-matching byte pairs ignored
    set_c1(1'b1);
    xchg("R1 wrong first byte", 8'hD8, 8'hC9, 0, 0, 0, 0, 0);
    xchg("R1 byte C7", 8'hD9, 8'hC7, 0, 0, 0, 0, 0);
    xchg("R1 byte D0", 8'hD9, 8'hD0, 1, 1, 0, 1, 1);

    // R5 R6 R7 R9: every fault input combination
    for (int c = 0; c < 16; c++) begin
      set_top(3'(c)); fill(200 + c); set_c1(1'b1);
      xchg("R5 R6 R7 R9 priority", 8'hD9, 8'hCB, c[0], c[1], c[2], c[3], 0);
    end

    // R8: underflow, unmasked and masked
    set_top(3'd5); fill(300); free(3'd2); set_c1(1'b1);
    xchg("R8 unmasked", 8'hD9, 8'hCA, 0, 0, 0, 0, 0);
    set_c1(1'b1);
    xchg("R8 masked", 8'hD9, 8'hCA, 0, 0, 0, 0, 1);
    free(3'd0); free(3'd4); set_c1(1'b1);
    xchg("R8 both empty masked", 8'hD9, 8'hCC, 0, 0, 0, 0, 1);
    free(3'd0);
    xchg("R8 self empty masked", 8'hD9, 8'hC8, 0, 0, 0, 0, 1);
    free(3'd6); set_c1(1'b1);
    xchg("R8 R5 lock beats underflow", 8'hD9, 8'hCE, 1, 0, 0, 0, 1);
    xchg("R8 R7 pending beats underflow", 8'hD9, 8'hCE, 0, 0, 0, 1, 1);

    // R10: debug writes ignored while issue is high
    set_c1(1'b0);
    dbg_idx = 3'd1; dbg_wdata = 80'h1234; dbg_we = 1; dbg_top = 3'd7; dbg_top_we = 1;
    dbg_c1 = 1; dbg_c1_we = 1;
    op_b0 = 8'h00; op_b1 = 8'h00; issue = 1;
    tick();
    issue = 0; dbg_we = 0; dbg_top_we = 0; dbg_c1_we = 0;
    check_state("R10 debug blocked by issue");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule